// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two two-level predictors side by side. The first keeps a short outcome history for each branch, selected by PC bits, and uses that history to pick a 2-bit saturating counter. The second keeps one shift register of the most recent outcomes of all branches and uses it to pick a counter in its own table. A third table of 2-bit counters, indexed by PC bits, learns for each branch which of the two is more reliable and steers the final multiplexer.

The fetch side presents a branch PC on the lookup port and gets the final guess and both component guesses back in the same cycle, with no clock edge in between. Once the branch resolves, the back end presents the PC, the real outcome and the two component guesses recorded at lookup time on the training port. One clock edge later the counters, the histories and the chooser have been trained. Histories are written only at training time, so a lookup always sees the state left by the last completed training.

Top module: `tournament_predictor`

## Requirements
- R1: Every 2-bit counter saturates. A taken training raises it by one up to 3, a not-taken training lowers it by one down to 0, and it never wraps.
- R2: A counter votes taken exactly when its value is 2 or 3 (bit 1 set).
- R3: The global history is 12 bits wide. Each training shifts it left and puts the real outcome into bit 0. Its value alone indexes a table of 4096 counters, and the counter at the pre-shift history is the one trained.
- R4: The local side holds 1024 histories of 10 bits, indexed by PC bits [11:2]. The selected history indexes a table of 1024 counters. Training updates the counter at the pre-shift history, then shifts the outcome into bit 0 of that history.
- R5: The chooser holds 4096 counters indexed by PC bits [13:2]. A chooser value of 2 or more selects the global vote, otherwise the local vote. The lookup result appears in the same cycle as the lookup PC.
- R6: On training, the chooser entry of the PC moves one step toward the global side if the global guess matched the outcome, and one step toward the local side otherwise. It moves only when the two component guesses differed.
- R7: After reset every component counter is 1, every chooser counter is 2, and all histories are zero. Every lookup then returns not-taken from both components and selects the global side.
- R8: While the training valid input is low, the other training inputs have no effect on any later lookup result.
- R9: A lookup in the same cycle as a training reflects the state before that training. The training takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_pc | input | 32 | PC of the branch being looked up |
| pred_taken | output | 1 | Final direction guess, 1 = taken |
| pred_local_taken | output | 1 | Local component guess |
| pred_global_taken | output | 1 | Global component guess |
| pred_use_global | output | 1 | 1 when the chooser selects the global guess |
| upd_valid | input | 1 | Training request for this cycle |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| upd_local_taken | input | 1 | Local guess recorded at lookup time |
| upd_global_taken | input | 1 | Global guess recorded at lookup time |

## Verification
All four lookup outputs are combinational from the lookup PC and the stored state. The bench therefore sets the lookup PC and the training inputs together just after a falling edge and samples the outputs one time unit later, before the next rising edge. A training presented in that cycle is applied by its bench reference model only after the following rising edge, so it first shows up in the lookup of the next step, exactly one cycle after it was presented. The same-cycle sample also covers the rule that a lookup sees the state before a training presented at the same time.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

   typedef logic [1:0] ctr2_t;

   localparam ctr2_t CTR_MIN     = 2'd0;
   localparam ctr2_t CTR_WEAK_NT = 2'd1;
   localparam ctr2_t CTR_WEAK_T  = 2'd2;
   localparam ctr2_t CTR_MAX     = 2'd3;

   // one saturating step of a 2-bit counter
   function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
      ctr2_t r;
      if (up) r = (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
      else    r = (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
      return r;
   endfunction

   function automatic logic ctr_vote(input ctr2_t c);
      return c[1];
   endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
   import tbp_pkg::*;
#(
   parameter int    IDX_W     = 10,
   parameter ctr2_t RESET_VAL = CTR_WEAK_NT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr2_t            rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);
   localparam int DEPTH = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 14) begin : g_bad_idx
      $error("tbp_ctr_table: IDX_W out of range");
   end

   ctr2_t mem [DEPTH];

   assign rd_ctr = mem[rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= RESET_VAL;
      end else if (wr_en) begin
         mem[wr_idx] <= ctr_step(mem[wr_idx], wr_up);
      end
   end

endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
   parameter int IDX_W  = 10,
   parameter int HIST_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [HIST_W-1:0] rd_hist,
   input  logic [IDX_W-1:0]  wr_idx,
   output logic [HIST_W-1:0] wr_hist_old,
   input  logic              wr_en,
   input  logic              wr_taken
);
   localparam int DEPTH = 1 << IDX_W;

   if (HIST_W < 2 || HIST_W > 14) begin : g_bad_hist
      $error("tbp_hist_table: HIST_W out of range");
   end
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("tbp_hist_table: IDX_W out of range");
   end

   logic [HIST_W-1:0] hist [DEPTH];

   assign rd_hist     = hist[rd_idx];
   assign wr_hist_old = hist[wr_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      end else if (wr_en) begin
         hist[wr_idx] <= {wr_hist_old[HIST_W-2:0], wr_taken};
      end
   end

endmodule

// File: rtl/tbp_shift_hist.sv
module tbp_shift_hist #(
   parameter int HIST_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_in,
   output logic [HIST_W-1:0] hist
);
   if (HIST_W < 2 || HIST_W > 14) begin : g_bad_hist
      $error("tbp_shift_hist: HIST_W out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        hist <= '0;
      else if (shift_en) hist <= {hist[HIST_W-2:0], shift_in};
   end

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
   import tbp_pkg::*;
#(
   parameter int    PC_W          = 32,
   parameter int    ALIGN_BITS    = 2,
   parameter int    GHIST_W       = 12,
   parameter int    LHT_IDX_W     = 10,
   parameter int    LHIST_W       = 10,
   parameter int    CHOOSE_IDX_W  = 12,
   parameter bit    GLOBAL_PC_XOR = 1'b0,
   parameter ctr2_t CHOOSE_RESET  = CTR_WEAK_T
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] pred_pc,
   output logic            pred_taken,
   output logic            pred_local_taken,
   output logic            pred_global_taken,
   output logic            pred_use_global,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic            upd_local_taken,
   input  logic            upd_global_taken
);
   localparam int G_PC_BITS = GLOBAL_PC_XOR ? GHIST_W : 0;
   localparam int MAX_IDX_W =
      (LHT_IDX_W > CHOOSE_IDX_W)
         ? ((LHT_IDX_W > G_PC_BITS) ? LHT_IDX_W : G_PC_BITS)
         : ((CHOOSE_IDX_W > G_PC_BITS) ? CHOOSE_IDX_W : G_PC_BITS);

   if (ALIGN_BITS + MAX_IDX_W > PC_W) begin : g_bad_pc
      $error("tournament_predictor: PC too narrow for the index fields");
   end
   if (ALIGN_BITS < 0) begin : g_bad_align
      $error("tournament_predictor: ALIGN_BITS negative");
   end

   // ---------------- index fields ----------------
   logic [LHT_IDX_W-1:0]    lht_pred_idx, lht_upd_idx;
   logic [CHOOSE_IDX_W-1:0] ch_pred_idx, ch_upd_idx;
   logic [GHIST_W-1:0]      ghist;
   logic [GHIST_W-1:0]      g_pred_idx, g_upd_idx;

   assign lht_pred_idx = pred_pc[ALIGN_BITS +: LHT_IDX_W];
   assign lht_upd_idx  = upd_pc[ALIGN_BITS +: LHT_IDX_W];
   assign ch_pred_idx  = pred_pc[ALIGN_BITS +: CHOOSE_IDX_W];
   assign ch_upd_idx   = upd_pc[ALIGN_BITS +: CHOOSE_IDX_W];

   if (GLOBAL_PC_XOR) begin : g_gidx_hash
      assign g_pred_idx = ghist ^ pred_pc[ALIGN_BITS +: GHIST_W];
      assign g_upd_idx  = ghist ^ upd_pc[ALIGN_BITS +: GHIST_W];
   end else begin : g_gidx_plain
      assign g_pred_idx = ghist;
      assign g_upd_idx  = ghist;
   end

   logic unused_pc_bits;
   assign unused_pc_bits = ^{pred_pc, upd_pc};

   // ---------------- global component ----------------
   ctr2_t g_pred_ctr;

   tbp_shift_hist #(.HIST_W(GHIST_W)) u_ghist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (upd_valid),
      .shift_in (upd_taken),
      .hist     (ghist)
   );

   tbp_ctr_table #(.IDX_W(GHIST_W), .RESET_VAL(CTR_WEAK_NT)) u_gctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (g_pred_idx),
      .rd_ctr (g_pred_ctr),
      .wr_en  (upd_valid),
      .wr_idx (g_upd_idx),
      .wr_up  (upd_taken)
   );

   // ---------------- local component ----------------
   logic [LHIST_W-1:0] lhist_pred, lhist_upd;
   ctr2_t              l_pred_ctr;

   tbp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lhist (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_idx      (lht_pred_idx),
      .rd_hist     (lhist_pred),
      .wr_idx      (lht_upd_idx),
      .wr_hist_old (lhist_upd),
      .wr_en       (upd_valid),
      .wr_taken    (upd_taken)
   );

   tbp_ctr_table #(.IDX_W(LHIST_W), .RESET_VAL(CTR_WEAK_NT)) u_lctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (lhist_pred),
      .rd_ctr (l_pred_ctr),
      .wr_en  (upd_valid),
      .wr_idx (lhist_upd),
      .wr_up  (upd_taken)
   );

   // ---------------- chooser ----------------
   ctr2_t ch_pred_val;
   logic  ch_train, ch_toward_global;

   assign ch_train         = upd_valid && (upd_local_taken != upd_global_taken);
   assign ch_toward_global = (upd_global_taken == upd_taken);

   tbp_ctr_table #(.IDX_W(CHOOSE_IDX_W), .RESET_VAL(CHOOSE_RESET)) u_chooser (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (ch_pred_idx),
      .rd_ctr (ch_pred_val),
      .wr_en  (ch_train),
      .wr_idx (ch_upd_idx),
      .wr_up  (ch_toward_global)
   );

   // ---------------- output select ----------------
   always_comb begin
      pred_local_taken  = ctr_vote(l_pred_ctr);
      pred_global_taken = ctr_vote(g_pred_ctr);
      pred_use_global   = ctr_vote(ch_pred_val);
      pred_taken        = pred_use_global ? pred_global_taken : pred_local_taken;
   end

endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
   parameter int PC_W    = 32,
   parameter int GHIST_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic [PC_W-1:0]    pred_pc,
   input logic               pred_taken,
   input logic               pred_local_taken,
   input logic               pred_global_taken,
   input logic               pred_use_global,
   input logic               upd_valid,
   input logic [PC_W-1:0]    upd_pc,
   input logic               upd_taken,
   input logic               upd_local_taken,
   input logic               upd_global_taken,
   input logic [GHIST_W-1:0] ghist,
   input logic [1:0]         ch_pred_val
);
   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R7: first cycle out of reset shows cleared history and global preference
   p_reset_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> (ghist == '0) && (ch_pred_val == 2'd2));

   // R5: with equal component votes the final vote follows them
   p_agree_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_local_taken == pred_global_taken) |-> (pred_taken == pred_local_taken));

   // R8: without training, a fixed PC keeps its lookup results
   p_hold_pred_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (!$past(upd_valid) && $stable(pred_pc)) |->
         $stable({pred_taken, pred_local_taken, pred_global_taken, pred_use_global}));

   // R8: global history frozen without training
   p_ghist_hold_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !$past(upd_valid) |-> $stable(ghist));

   // R3: the real outcome lands in bit 0 of the global history
   p_ghist_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(upd_valid) |-> (ghist[0] == $past(upd_taken)));

   // R6: chooser entry untouched when the components agreed
   p_chooser_hold_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(upd_valid && (upd_local_taken == upd_global_taken) && (pred_pc == upd_pc))
       && $stable(pred_pc)) |-> $stable(ch_pred_val));

   // R1: chooser at the top stays at the top when pushed further up
   p_chooser_sat_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(upd_valid && (upd_local_taken != upd_global_taken)
             && (upd_global_taken == upd_taken) && (pred_pc == upd_pc)
             && (ch_pred_val == 2'd3))
       && $stable(pred_pc)) |-> (ch_pred_val == 2'd3));

endmodule

bind tournament_predictor tbp_checker #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_tbp_checker (
   .clk               (clk),
   .rst_n             (rst_n),
   .pred_pc           (pred_pc),
   .pred_taken        (pred_taken),
   .pred_local_taken  (pred_local_taken),
   .pred_global_taken (pred_global_taken),
   .pred_use_global   (pred_use_global),
   .upd_valid         (upd_valid),
   .upd_pc            (upd_pc),
   .upd_taken         (upd_taken),
   .upd_local_taken   (upd_local_taken),
   .upd_global_taken  (upd_global_taken),
   .ghist             (ghist),
   .ch_pred_val       (ch_pred_val)
);

// File: tb/tournament_predictor_test.sv
module tournament_predictor_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pred_pc = '0;
   logic        pred_taken, pred_local_taken, pred_global_taken, pred_use_global;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0, upd_local_taken = 1'b0, upd_global_taken = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tournament_predictor uut (
      .clk (clk), .rst_n (rst_n),
      .pred_pc (pred_pc), .pred_taken (pred_taken),
      .pred_local_taken (pred_local_taken), .pred_global_taken (pred_global_taken),
      .pred_use_global (pred_use_global),
      .upd_valid (upd_valid), .upd_pc (upd_pc), .upd_taken (upd_taken),
      .upd_local_taken (upd_local_taken), .upd_global_taken (upd_global_taken)
   );

   // ---------------- reference model built from the requirements ----------------
   bit [1:0]  m_g  [4096];
   bit [1:0]  m_l  [1024];
   bit [1:0]  m_c  [4096];
   bit [9:0]  m_lh [1024];
   bit [11:0] m_gh;

   function automatic bit [1:0] sat(input bit [1:0] c, input bit up);
      if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
      return (c == 2'd0) ? 2'd0 : c - 2'd1;
   endfunction

   task automatic m_reset();
      for (int i = 0; i < 4096; i++) begin m_g[i] = 2'd1; m_c[i] = 2'd2; end
      for (int i = 0; i < 1024; i++) begin m_l[i] = 2'd1; m_lh[i] = '0; end
      m_gh = '0;
   endtask

   function automatic bit m_local(input bit [31:0] pc);
      return m_l[m_lh[pc[11:2]]][1];
   endfunction
   function automatic bit m_global();
      return m_g[m_gh][1];
   endfunction
   function automatic bit m_sel(input bit [31:0] pc);
      return m_c[pc[13:2]][1];
   endfunction

   task automatic m_train(input bit [31:0] pc, input bit t, input bit lp, input bit gp);
      bit [9:0] lh;
      lh = m_lh[pc[11:2]];
      m_l[lh] = sat(m_l[lh], t);
      m_g[m_gh] = sat(m_g[m_gh], t);
      if (lp != gp) m_c[pc[13:2]] = sat(m_c[pc[13:2]], gp == t);
      m_lh[pc[11:2]] = {lh[8:0], t};
      m_gh = {m_gh[10:0], t};
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // one cycle: lookup pc, optional training on tpc, outputs sampled before the edge
   task automatic step(input string req, input bit [31:0] pc, input bit [31:0] tpc,
                       input bit tv, input bit t, input bit force_comp,
                       input bit flp, input bit fgp);
      bit el, eg, es, tl, tg;
      @(negedge clk);
      el = m_local(pc); eg = m_global(); es = m_sel(pc);
      tl = force_comp ? flp : m_local(tpc);
      tg = force_comp ? fgp : m_global();
      pred_pc = pc; upd_valid = tv; upd_pc = tpc; upd_taken = t;
      upd_local_taken = tl; upd_global_taken = tg;
      #1;
      chk({req, " R4"}, "local vote", pred_local_taken, el);
      chk({req, " R3"}, "global vote", pred_global_taken, eg);
      chk({req, " R5"}, "chooser select", pred_use_global, es);
      chk({req, " R5"}, "final vote", pred_taken, es ? eg : el);
      @(posedge clk);
      if (tv) m_train(tpc, t, tl, tg);
   endtask

   task automatic go(input string req, input bit [31:0] pc, input bit t);
      step(req, pc, pc, 1'b1, t, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      bit [31:0] pool [16];
      process::self().srandom(32'h5eed_1234);
      for (int i = 0; i < 16; i++) pool[i] = 32'h0040_0000 + (i * 32'h0000_0104);
      m_reset();
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R7: reset state for a spread of PCs, no training
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); pred_pc = $urandom; #1;
         chk("R7", "reset final vote", pred_taken, 0);
         chk("R7", "reset local vote", pred_local_taken, 0);
         chk("R7", "reset global vote", pred_global_taken, 0);
         chk("R7", "reset chooser select", pred_use_global, 1);
      end

      // R1/R2: drive one branch up into saturation and back down
      for (int i = 0; i < 16; i++) go("R1 R2 rising", 32'h0000_1000, 1'b1);
      for (int i = 0; i < 16; i++) go("R1 R2 falling", 32'h0000_1000, 1'b0);

      // R9: lookup and training of the same branch in one cycle
      for (int i = 0; i < 8; i++) go("R9 same-cycle", 32'h0000_2008, 1'b1);

      // R6: forced disagreement drives one chooser entry both ways and saturates it
      for (int i = 0; i < 5; i++)
         step("R6 toward local", 32'h0000_3000, 32'h0000_3000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      for (int i = 0; i < 5; i++)
         step("R6 toward global", 32'h0000_3000, 32'h0000_3000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
      for (int i = 0; i < 3; i++)
         step("R6 agreeing", 32'h0000_3000, 32'h0000_3000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);

      // R8: junk on the training inputs with valid low
      for (int i = 0; i < 12; i++)
         step("R8 ignored", pool[i], $urandom, 1'b0, $urandom, 1'b1, $urandom, $urandom);

      // R3/R4: loop-shaped branches plus random ones, interleaved
      for (int n = 0; n < 3000; n++) begin
         int k;
         bit t;
         k = $urandom_range(0, 15);
         case (k % 4)
            0: t = (n % 5) != 0;
            1: t = (n % 3) == 0;
            2: t = 1'b1;
            default: t = $urandom_range(0, 1);
         endcase
         if (n % 7 == 0)
            step("R6 random", pool[k], pool[k], 1'b1, t, 1'b1, $urandom, $urandom);
         else if (n % 11 == 0)
            step("R9 cross", pool[(k + 1) % 16], pool[k], 1'b1, t, 1'b0, 1'b0, 1'b0);
         else
            go("R3 R4 mix", pool[k], t);
      end

      // R7: reset again after training
      @(negedge clk); rst_n = 1'b0; upd_valid = 1'b0;
      @(posedge clk); m_reset();
      @(negedge clk); rst_n = 1'b1; pred_pc = pool[3]; #1;
      chk("R7", "re-reset final vote", pred_taken, 0);
      chk("R7", "re-reset chooser select", pred_use_global, 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule